// File: doc/BRIEF.md
# Debug Module Register Interface

This block is the register file that a debug transport talks to over a small parallel bus. The bus has an 8-bit offset, 32-bit write and read data, and separate write and read strobes. Read data appears one cycle after the read strobe. Behind the bus sit the following registers:

- a set of abstract data words;
- a run-control word that keeps only its defined bits;
- a read-only status word built from the hart's halted level;
- an abstract-command status word;
- the command word;
- a fixed device-tree pointer;
- a halt summary that captures the halted level at reset.

Writing the command word decodes its type byte. A register-access or memory-access command launches: one cycle later the block raises a single-cycle start pulse, presents the decoded argument fields, and holds a busy flag. Busy stays high until the executing logic pulses the done input. A command written while busy is refused and records the busy error code. The error field is cleared by writing ones to the bits to be cleared.

Top module: `dbgreg_hub`

## Requirements
- R1: After reset the data words, the run-control word and the command word read 0. Busy and start are 0. The halt summary reads 1 in bit 0 if `halted_in` was high during reset, and 0 in all other bits.
- R2: The data words live at offsets 0x04 upward, one per word (0x04 to 0x07 by default). Each reads back the last value written to it. `bus_rdata` shows the value in the cycle after the one in which `bus_rd` was high.
- R3: A write to the run-control word at 0x10 keeps only bits 31, 30, 29, 28, 26, 16, 3 and 2 (mask 0xF401000C). All other bits of that word read 0.
- R4: The status word at 0x11 reads as follows, and bus writes to it have no effect:
  - version in bits 3:0 (default 2);
  - bit 7 is 1;
  - bits 9 and 8 both equal `halted_in`;
  - bits 11 and 10 both equal the inverse of `halted_in`;
  - all other bits are 0.
- R5: Reads of any offset that has no register return 0. Writes to such offsets change no register.
- R6: A command write (offset 0x17) with type byte (bits 31:24) equal to 0x00, made while idle, raises `cmd_start` for exactly the next cycle with `cmd_is_mem` = 0. The register-access fields come from the written word as follows: size from bits 22:20, postexec from bit 18, transfer from bit 17, write from bit 16, register number from bits 15:0.
- R7: A command write with type 0x02, made while idle, raises `cmd_start` for the next cycle with `cmd_is_mem` = 1. The memory-access fields come from the written word as follows: virtual from bit 23, size from bits 22:20, postincrement from bit 19, write from bit 16, target-specific from bits 15:14.
- R8: A command write with any other type (including 0x01) raises no start, sets no busy and leaves the error field unchanged.
- R9: `cmd_busy` rises together with `cmd_start` and stays high until the cycle after a `cmd_done` pulse. `cmd_done` while idle has no effect.
- R10: A command write while busy raises no start, sets the error field to 1, and leaves the presented argument fields unchanged.
- R11: A write to 0x16 clears each error bit (bits 10:8) written as 1. Error bits written as 0 keep their value.
- R12: Offset 0x17 reads back the last command word written, whether or not that write launched a command.
- R13: The abstract status word at 0x16 reads as follows:
  - progbufsize 0 in bits 28:24;
  - busy in bit 12;
  - the error field in bits 10:8;
  - the number of data words in bits 3:0;
  - all other bits are 0.
- R14: The device-tree pointer at 0x19 reads the `DEVTREE_ADDR` parameter. Bus writes to 0x19 and to the halt summary at 0x40 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| halted_in | input | 1 | Hart halted level |
| cmd_done | input | 1 | Pulse from the executor ending the running command |
| cmd_start | output | 1 | One-cycle launch pulse |
| cmd_busy | output | 1 | Command in flight |
| cmd_is_mem | output | 1 | 1 for memory access, 0 for register access |
| ra_size | output | 3 | Register access size |
| ra_postexec | output | 1 | Register access postexec flag |
| ra_transfer | output | 1 | Register access transfer flag |
| ra_write | output | 1 | Register access direction |
| ra_regno | output | 16 | Register number |
| ma_virtual | output | 1 | Memory access uses virtual addresses |
| ma_size | output | 3 | Memory access size |
| ma_postinc | output | 1 | Memory access post-increment |
| ma_write | output | 1 | Memory access direction |
| ma_target | output | 2 | Memory access target-specific bits |

## Verification
The command path is driven with each of the following, and each separates a different fault:
- A register-access word whose fields all differ from one another. This exposes a swapped or misplaced field.
- A memory-access word with the virtual, postincrement and target bits set. This separates the two argument layouts.
- Types 0x01 and 0xFF. These must launch nothing.
- A launch attempt while busy. This must leave the previous arguments in place and record error code 1.

On the register side, the data words get distinct patterns so that an address-decode slip reads the wrong word. Writes are sent to unmapped and read-only offsets, then the neighbours are read back. The run-control word is written with all ones and with a sparse pattern to check its mask. The error field is cleared bit by bit to show that zeros preserve.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    localparam int WORD_W = 32;

    // Register offsets on the debug bus
    localparam logic [7:0] OFS_DATA0 = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h11;
    localparam logic [7:0] OFS_ACS   = 8'h16;
    localparam logic [7:0] OFS_CMD   = 8'h17;
    localparam logic [7:0] OFS_DTREE = 8'h19;
    localparam logic [7:0] OFS_HSUM  = 8'h40;

    // Command type codes that launch
    localparam logic [7:0] KIND_REG = 8'h00;
    localparam logic [7:0] KIND_MEM = 8'h02;

    localparam logic [2:0]        ERR_BUSY  = 3'd1;
    localparam logic [WORD_W-1:0] CTRL_KEEP = 32'hF401_000C;

    typedef struct packed {
        logic [2:0]  size;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } reg_arg_t;

    typedef struct packed {
        logic       virt;
        logic [2:0] size;
        logic       postinc;
        logic       write;
        logic [1:0] target;
    } mem_arg_t;

    typedef struct packed {
        logic     busy;
        logic     start;
        logic [2:0] err;
        logic     is_mem;
        reg_arg_t ra;
        mem_arg_t ma;
    } seq_state_t;

endpackage

// File: rtl/dbgreg_cmd_decode.sv
module dbgreg_cmd_decode
    import dbgreg_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output logic              launch,
    output logic              is_mem,
    output reg_arg_t          reg_arg,
    output mem_arg_t          mem_arg
);

    logic [7:0]  kind;
    logic [23:0] arg;

    always_comb begin
        kind   = cmd_word[31:24];
        arg    = cmd_word[23:0];
        is_mem = (kind == KIND_MEM);
        launch = (kind == KIND_REG) || (kind == KIND_MEM);

        reg_arg.size     = arg[22:20];
        reg_arg.postexec = arg[18];
        reg_arg.transfer = arg[17];
        reg_arg.write    = arg[16];
        reg_arg.regno    = arg[15:0];

        mem_arg.virt     = arg[23];
        mem_arg.size     = arg[22:20];
        mem_arg.postinc  = arg[19];
        mem_arg.write    = arg[16];
        mem_arg.target   = arg[15:14];
    end

endmodule

// File: rtl/dbgreg_abs_seq.sv
module dbgreg_abs_seq
    import dbgreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       launch,
    input  logic       is_mem_in,
    input  reg_arg_t   ra_in,
    input  mem_arg_t   ma_in,
    input  logic       done,
    input  logic       cs_wr,
    input  logic [2:0] clr_mask,
    output logic       busy,
    output logic       start,
    output logic [2:0] err,
    output logic       is_mem,
    output reg_arg_t   ra,
    output mem_arg_t   ma
);

    seq_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (s_q.busy && done) begin
            s_d.busy = 1'b0;
        end
        if (cs_wr) begin
            s_d.err = s_q.err & ~clr_mask;
        end
        if (cmd_wr) begin
            if (s_q.busy) begin
                s_d.err = ERR_BUSY;
            end else if (launch) begin
                s_d.start  = 1'b1;
                s_d.busy   = 1'b1;
                s_d.is_mem = is_mem_in;
                s_d.ra     = ra_in;
                s_d.ma     = ma_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign start  = s_q.start;
    assign err    = s_q.err;
    assign is_mem = s_q.is_mem;
    assign ra     = s_q.ra;
    assign ma     = s_q.ma;

endmodule

// File: rtl/dbgreg_hub.sv
module dbgreg_hub
    import dbgreg_pkg::*;
#(
    parameter int              NUM_DATA     = 4,
    parameter logic [3:0]      VERSION      = 4'd2,
    parameter logic [31:0]     DEVTREE_ADDR = 32'h0000_4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic        halted_in,
    input  logic        cmd_done,
    output logic        cmd_start,
    output logic        cmd_busy,
    output logic        cmd_is_mem,
    output logic [2:0]  ra_size,
    output logic        ra_postexec,
    output logic        ra_transfer,
    output logic        ra_write,
    output logic [15:0] ra_regno,
    output logic        ma_virtual,
    output logic [2:0]  ma_size,
    output logic        ma_postinc,
    output logic        ma_write,
    output logic [1:0]  ma_target
);

    localparam logic [3:0] DCOUNT = 4'(NUM_DATA);

    typedef struct packed {
        logic [NUM_DATA-1:0][WORD_W-1:0] data;
        logic [WORD_W-1:0]               ctrl;
        logic [WORD_W-1:0]               cmd;
        logic [WORD_W-1:0]               hsum;
        logic [WORD_W-1:0]               rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_DATA-1:0] data_sel;
    logic                dec_launch, dec_is_mem;
    reg_arg_t            dec_ra, seq_ra;
    mem_arg_t            dec_ma, seq_ma;
    logic [2:0]          abs_err;
    logic                cmd_wr, cs_wr;
    logic [WORD_W-1:0]   stat_word, acs_word, rd_val;

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_dsel
        assign data_sel[g] = (bus_addr == OFS_DATA0 + 8'(g));
    end

    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD);
    assign cs_wr  = bus_wr && (bus_addr == OFS_ACS);

    dbgreg_cmd_decode u_dec (
        .cmd_word (bus_wdata),
        .launch   (dec_launch),
        .is_mem   (dec_is_mem),
        .reg_arg  (dec_ra),
        .mem_arg  (dec_ma)
    );

    dbgreg_abs_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .launch    (dec_launch),
        .is_mem_in (dec_is_mem),
        .ra_in     (dec_ra),
        .ma_in     (dec_ma),
        .done      (cmd_done),
        .cs_wr     (cs_wr),
        .clr_mask  (bus_wdata[10:8]),
        .busy      (cmd_busy),
        .start     (cmd_start),
        .err       (abs_err),
        .is_mem    (cmd_is_mem),
        .ra        (seq_ra),
        .ma        (seq_ma)
    );

    always_comb begin
        stat_word = {20'b0, ~halted_in, ~halted_in, halted_in, halted_in,
                     1'b1, 3'b0, VERSION};
        acs_word  = {3'b0, 5'd0, 11'b0, cmd_busy, 1'b0, abs_err, 4'b0, DCOUNT};

        rd_val = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (data_sel[i]) rd_val = r_q.data[i];
        end
        case (bus_addr)
            OFS_CTRL:  rd_val = r_q.ctrl;
            OFS_STAT:  rd_val = stat_word;
            OFS_ACS:   rd_val = acs_word;
            OFS_CMD:   rd_val = r_q.cmd;
            OFS_DTREE: rd_val = DEVTREE_ADDR;
            OFS_HSUM:  rd_val = r_q.hsum;
            default:   ;
        endcase

        r_d = r_q;
        if (bus_rd) r_d.rdata = rd_val;
        if (bus_wr) begin
            for (int i = 0; i < NUM_DATA; i++) begin
                if (data_sel[i]) r_d.data[i] = bus_wdata;
            end
            if (bus_addr == OFS_CTRL) r_d.ctrl = bus_wdata & CTRL_KEEP;
            if (bus_addr == OFS_CMD)  r_d.cmd  = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.hsum <= {31'b0, halted_in};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata   = r_q.rdata;
    assign ra_size     = seq_ra.size;
    assign ra_postexec = seq_ra.postexec;
    assign ra_transfer = seq_ra.transfer;
    assign ra_write    = seq_ra.write;
    assign ra_regno    = seq_ra.regno;
    assign ma_virtual  = seq_ma.virt;
    assign ma_size     = seq_ma.size;
    assign ma_postinc  = seq_ma.postinc;
    assign ma_write    = seq_ma.write;
    assign ma_target   = seq_ma.target;

endmodule

// File: rtl/dbgreg_hub_chk.sv
module dbgreg_hub_chk #(
    parameter int NUM_DATA = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        cmd_done,
    input logic        cmd_start,
    input logic        cmd_busy,
    input logic [15:0] ra_regno,
    input logic [2:0]  abs_err
);

    logic mapped, cmd_hit;

    always_comb begin
        mapped = (int'(bus_addr) >= 4 && int'(bus_addr) < 4 + NUM_DATA)
              || bus_addr == 8'h10 || bus_addr == 8'h11 || bus_addr == 8'h16
              || bus_addr == 8'h17 || bus_addr == 8'h19 || bus_addr == 8'h40;
        cmd_hit = bus_wr && bus_addr == 8'h17;
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R6

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> cmd_busy); // R9

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !cmd_done |=> cmd_busy); // R9

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit && cmd_busy |=> !cmd_start && abs_err == 3'd1); // R10

    AST_ARG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !cmd_start |-> $stable(ra_regno)); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !mapped |=> bus_rdata == 32'h0); // R5

endmodule

bind dbgreg_hub dbgreg_hub_chk #(.NUM_DATA(NUM_DATA)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cmd_done  (cmd_done),
    .cmd_start (cmd_start),
    .cmd_busy  (cmd_busy),
    .ra_regno  (ra_regno),
    .abs_err   (abs_err)
);

// File: tb/tb_dbgreg_hub.sv
module tb_dbgreg_hub;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] DTREE      = 32'h0000_4000;

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h04, 32'h1111_1111, 4'd2},   // R2
        '{1'b0, 8'h05, 32'h2222_2222, 4'd2},
        '{1'b0, 8'h06, 32'hA5A5_A5A5, 4'd2},
        '{1'b0, 8'h07, 32'hFFFF_FFFF, 4'd2},
        '{1'b0, 8'h08, 32'hDEAD_BEEF, 4'd5},   // R5 unmapped write
        '{1'b0, 8'h11, 32'hFFFF_FFFF, 4'd4},   // R4 read-only
        '{1'b0, 8'h19, 32'h1234_5678, 4'd14},  // R14
        '{1'b0, 8'h40, 32'hFFFF_FFFF, 4'd14},
        '{1'b1, 8'h04, 32'h1111_1111, 4'd2},
        '{1'b1, 8'h05, 32'h2222_2222, 4'd2},
        '{1'b1, 8'h06, 32'hA5A5_A5A5, 4'd2},
        '{1'b1, 8'h07, 32'hFFFF_FFFF, 4'd2},
        '{1'b1, 8'h08, 32'h0000_0000, 4'd5},
        '{1'b1, 8'h03, 32'h0000_0000, 4'd5},
        '{1'b1, 8'hFF, 32'h0000_0000, 4'd5},
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 4'd3},   // R3
        '{1'b1, 8'h10, 32'hF401_000C, 4'd3},
        '{1'b0, 8'h10, 32'h0A0B_0C03, 4'd3},
        '{1'b1, 8'h10, 32'h0001_0000, 4'd3},
        '{1'b1, 8'h11, 32'h0000_0382, 4'd4},
        '{1'b1, 8'h19, DTREE,         4'd14},
        '{1'b1, 8'h40, 32'h0000_0001, 4'd14},
        '{1'b1, 8'h16, 32'h0000_0004, 4'd13}   // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        halted_in = 1'b1;
    logic        cmd_done = 1'b0;
    logic        cmd_start, cmd_busy, cmd_is_mem;
    logic [2:0]  ra_size, ma_size;
    logic        ra_postexec, ra_transfer, ra_write;
    logic [15:0] ra_regno;
    logic        ma_virtual, ma_postinc, ma_write;
    logic [1:0]  ma_target;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbgreg_hub #(.NUM_DATA(4), .VERSION(4'd2), .DEVTREE_ADDR(DTREE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .halted_in(halted_in), .cmd_done(cmd_done), .cmd_start(cmd_start),
        .cmd_busy(cmd_busy), .cmd_is_mem(cmd_is_mem), .ra_size(ra_size),
        .ra_postexec(ra_postexec), .ra_transfer(ra_transfer), .ra_write(ra_write),
        .ra_regno(ra_regno), .ma_virtual(ma_virtual), .ma_size(ma_size),
        .ma_postinc(ma_postinc), .ma_write(ma_write), .ma_target(ma_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 busy", {31'b0, cmd_busy}, 32'h0);
        check("R1 start", {31'b0, cmd_start}, 32'h0);
        bus_read(8'h04, v); check("R1 data0", v, 32'h0);
        bus_read(8'h10, v); check("R1 ctrl", v, 32'h0);
        bus_read(8'h17, v); check("R1 cmd", v, 32'h0);
        bus_read(8'h40, v); check("R1 haltsum", v, 32'h1);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_rd) begin
                bus_read(VECS[i].addr, v);
                n_chk++;
                if (v !== VECS[i].data) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d addr %h actual=%h expected=%h",
                             VECS[i].req, i, VECS[i].addr, v, VECS[i].data);
                end
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R6 register access launch
        bus_write(8'h17, 32'h0023_1005);
        check("R6 start", {31'b0, cmd_start}, 32'h1);
        check("R6 is_mem", {31'b0, cmd_is_mem}, 32'h0);
        check("R6 fields", {8'b0, ra_size, ra_postexec, ra_transfer, ra_write, ra_regno},
              {8'b0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1005});
        check("R9 busy at start", {31'b0, cmd_busy}, 32'h1);
        @(negedge clk);
        check("R6 start one cycle", {31'b0, cmd_start}, 32'h0);
        check("R9 busy held", {31'b0, cmd_busy}, 32'h1);

        // R10 refused while busy
        bus_write(8'h17, 32'h0200_0000);
        check("R10 no start", {31'b0, cmd_start}, 32'h0);
        check("R10 args kept", {15'b0, cmd_is_mem, ra_regno}, {15'b0, 1'b0, 16'h1005});
        bus_read(8'h16, v); check("R10 err busy", v, 32'h0000_1104);
        bus_read(8'h17, v); check("R12 cmd readback", v, 32'h0200_0000);

        // R9 done ends busy
        pulse_done();
        check("R9 busy cleared", {31'b0, cmd_busy}, 32'h0);
        pulse_done();
        check("R9 idle done", {31'b0, cmd_busy}, 32'h0);

        // R11 write-one-to-clear
        bus_write(8'h16, 32'h0000_0200);
        bus_read(8'h16, v); check("R11 zero kept", v, 32'h0000_0104);
        bus_write(8'h16, 32'h0000_0100);
        bus_read(8'h16, v); check("R11 cleared", v, 32'h0000_0004);

        // R7 memory access launch
        bus_write(8'h17, 32'h029B_C000);
        check("R7 start", {31'b0, cmd_start}, 32'h1);
        check("R7 is_mem", {31'b0, cmd_is_mem}, 32'h1);
        check("R7 fields", {24'b0, ma_virtual, ma_size, ma_postinc, ma_write, ma_target},
              {24'b0, 1'b1, 3'd1, 1'b1, 1'b1, 2'd3});
        pulse_done();

        // R8 other types launch nothing
        bus_write(8'h17, 32'h0100_0000);
        check("R8 quick no start", {30'b0, cmd_start, cmd_busy}, 32'h0);
        bus_write(8'h17, 32'hFF00_0000);
        check("R8 ff no start", {30'b0, cmd_start, cmd_busy}, 32'h0);
        bus_read(8'h16, v); check("R8 err unchanged", v, 32'h0000_0004);
        bus_read(8'h17, v); check("R12 cmd readback", v, 32'hFF00_0000);

        // R4 status follows halted level
        halted_in = 1'b0;
        bus_read(8'h11, v); check("R4 running", v, 32'h0000_0C82);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule